// File: doc/BRIEF.md
# SD Transfer Suspend Coordinator

This block sits between the command engine and the data engine of an SD/SDIO host controller. It lets software pause a data transfer that is under way. Software issues a command and flags it as a suspend request. The command side then waits for the card's reply. If the card accepts, the command side sends a one-cycle acknowledge to the data side. A missing reply or an error reply means the request is dropped and the transfer carries on.

Once the data side holds the acknowledge, the direction of the transfer sets where it may stop:

- **Write:** it keeps the current block going and stops only when the card's CRC token for that block arrives.
- **Read:** it parks while the card delivers one final complete packet, then waits until software has emptied the receive FIFO, then goes idle.

In both directions a sticky flag records that the transfer ended through the suspend path. While a suspend is outstanding, the block refuses to start a new transfer.

Top module: `sdsus_ctrl`

## Requirements
- R1: After reset, `dstate` is 0 (idle), and `susp_ack`, `susp_pend` and `suspended` are all 0.
- R2: A `xfer_start` pulse while idle, with `susp_pend` low, moves `dstate` on the next edge. It goes to 1 (write) when `xfer_dir`=0 and to 2 (read) when `xfer_dir`=1.
- R3: After a `cmd_issue` with `cmd_suspend`=1, a `rsp_valid` with `rsp_ok`=1 that arrives within RSP_TMO cycles makes `susp_ack` high for exactly the one cycle after the response edge.
- R4: If the reply to a suspend command is an error (`rsp_valid` with `rsp_ok`=0), or does not arrive within RSP_TMO cycles, no `susp_ack` is given and `susp_pend` drops. A later `crc_tok` leaves a write in `dstate` 1.
- R5: A reply to a command issued with `cmd_suspend`=0 never produces `susp_ack`.
- R6: On a write, the acknowledge is latched into a sticky pending state on the edge after `susp_ack`. While it is pending, `dstate` stays 1 until a `crc_tok`; on that edge `dstate` becomes 0 and `suspended` becomes 1.
- R7: On a read, `dstate` goes 2 to 3 (parked) on the edge after the pending state is latched. It goes 3 to 4 (draining) on an `rd_pkt` strobe. It goes 4 to 0, setting `suspended`, on the first edge with `fifo_empty`=1; it holds 4 while `fifo_empty`=0.
- R8: `susp_pend` is high from the edge after a suspend `cmd_issue` until the reply is refused or times out, or until the data side ends the transfer. A `xfer_start` while `susp_pend` is high leaves `dstate` at 0.
- R9: `suspended` returns to 0 on the edge after the next `cmd_issue`.
- R10: `xfer_end` in any busy state returns `dstate` to 0, clears the pending state and leaves `suspended` at 0.
- R11: An acknowledge that arrives while idle latches nothing: `susp_pend` is 0 afterwards and a transfer can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_issue | input | 1 | One-cycle strobe: a command is sent |
| cmd_suspend | input | 1 | Marks the issued command as a suspend request |
| rsp_valid | input | 1 | One-cycle strobe: card reply received |
| rsp_ok | input | 1 | Reply is free of error (suspend accepted) |
| xfer_start | input | 1 | One-cycle request to begin a data transfer |
| xfer_dir | input | 1 | Transfer direction: 0 write, 1 read |
| xfer_end | input | 1 | Data path reports normal end of transfer |
| crc_tok | input | 1 | Card CRC token for the current write block received |
| rd_pkt | input | 1 | A complete read packet has been received |
| fifo_empty | input | 1 | Receive FIFO is empty |
| susp_ack | output | 1 | One-cycle acknowledge from command side to data side |
| susp_pend | output | 1 | A suspend is outstanding |
| dstate | output | 3 | Data state: 0 idle, 1 write, 2 read, 3 parked, 4 draining |
| suspended | output | 1 | Last transfer ended through the suspend path |

## Verification
The assertions take the following for granted about the inputs:
- Every strobe lasts one cycle.
- `rsp_valid` follows an issued command.
- `xfer_start` is raised only while idle.
- `xfer_end` is raised only during a transfer.

The stimulus drives each strobe for a single cycle from tasks on the falling edge. It sends replies only after an issue, and starts transfers only from idle. Strobes that have nothing to act on, such as a reply after a timeout or a start while a suspend is outstanding, are sent on purpose to show that they are ignored.

// File: rtl/sdsus_pkg.sv
package sdsus_pkg;
  localparam int DST_W = 3;
  typedef enum logic [DST_W-1:0] {
    DS_IDLE  = 3'd0,
    DS_WR    = 3'd1,
    DS_RD    = 3'd2,
    DS_PARK  = 3'd3,
    DS_DRAIN = 3'd4
  } dstate_t;
endpackage

// File: rtl/sdsus_cmd_side.sv
module sdsus_cmd_side #(
  parameter int RSP_TMO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_issue,
  input  logic cmd_suspend,
  input  logic rsp_valid,
  input  logic rsp_ok,
  output logic waiting,
  output logic ack
);
  localparam int TW = (RSP_TMO > 1) ? $clog2(RSP_TMO) : 1;
  localparam logic [TW-1:0] TLAST = TW'(RSP_TMO - 1);

  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      timer   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (cmd_issue) begin
        waiting <= cmd_suspend;
        timer   <= '0;
      end else if (waiting) begin
        if (rsp_valid) begin
          waiting <= 1'b0;
          ack     <= rsp_ok;
        end else if (timer == TLAST) begin
          waiting <= 1'b0;
        end else begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  // R3: acknowledge lasts one cycle only
  a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R4: refused reply never acknowledges
  a_r4_err_no_ack: assert property (@(posedge clk) disable iff (rst)
    (waiting && rsp_valid && !rsp_ok && !cmd_issue) |=> !ack);
  // R5: reply with nothing outstanding never acknowledges
  a_r5_plain_no_ack: assert property (@(posedge clk) disable iff (rst)
    (!waiting && !cmd_issue) |=> !ack);
endmodule

// File: rtl/sdsus_data_side.sv
module sdsus_data_side
  import sdsus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ack,
  input  logic    cmd_wait,
  input  logic    cmd_issue,
  input  logic    xfer_start,
  input  logic    xfer_dir,
  input  logic    xfer_end,
  input  logic    crc_tok,
  input  logic    rd_pkt,
  input  logic    fifo_empty,
  output dstate_t state,
  output logic    pend,
  output logic    suspended
);
  dstate_t nxt;
  logic    susp_stop;

  always_comb begin
    nxt       = state;
    susp_stop = 1'b0;
    if (state != DS_IDLE && xfer_end) begin
      nxt = DS_IDLE;
    end else begin
      case (state)
        DS_IDLE:  if (xfer_start && !pend && !cmd_wait)
                    nxt = xfer_dir ? DS_RD : DS_WR;
        DS_WR:    if (pend && crc_tok) begin
                    nxt       = DS_IDLE;
                    susp_stop = 1'b1;
                  end
        DS_RD:    if (pend) nxt = DS_PARK;
        DS_PARK:  if (rd_pkt) nxt = DS_DRAIN;
        DS_DRAIN: if (fifo_empty) begin
                    nxt       = DS_IDLE;
                    susp_stop = 1'b1;
                  end
        default:  nxt = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= DS_IDLE;
      pend      <= 1'b0;
      suspended <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == DS_IDLE)
        pend <= 1'b0;
      else if (ack && state != DS_IDLE)
        pend <= 1'b1;
      if (cmd_issue)
        suspended <= 1'b0;
      else if (susp_stop)
        suspended <= 1'b1;
    end
  end

  // R6: pending write stops on its CRC token
  a_r6_wr_stop: assert property (@(posedge clk) disable iff (rst)
    (state == DS_WR && pend && crc_tok && !xfer_end && !cmd_issue)
      |=> (state == DS_IDLE && suspended));
  // R7: drain holds until FIFO empty
  a_r7_drain_hold: assert property (@(posedge clk) disable iff (rst)
    (state == DS_DRAIN && !fifo_empty && !xfer_end) |=> state == DS_DRAIN);
  // R8: no start while a suspend is outstanding
  a_r8_start_block: assert property (@(posedge clk) disable iff (rst)
    (state == DS_IDLE && xfer_start && (pend || cmd_wait)) |=> state == DS_IDLE);
  // R9: command issue clears the suspended flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    cmd_issue |=> !suspended);
  // R10: normal end never marks suspended
  a_r10_end_plain: assert property (@(posedge clk) disable iff (rst)
    (state != DS_IDLE && xfer_end && !suspended) |=> (state == DS_IDLE && !suspended && !pend));
endmodule

// File: rtl/sdsus_ctrl.sv
module sdsus_ctrl
  import sdsus_pkg::*;
#(
  parameter int RSP_TMO = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_issue,
  input  logic             cmd_suspend,
  input  logic             rsp_valid,
  input  logic             rsp_ok,
  input  logic             xfer_start,
  input  logic             xfer_dir,
  input  logic             xfer_end,
  input  logic             crc_tok,
  input  logic             rd_pkt,
  input  logic             fifo_empty,
  output logic             susp_ack,
  output logic             susp_pend,
  output logic [DST_W-1:0] dstate,
  output logic             suspended
);
  logic    cmd_wait;
  logic    pend;
  dstate_t st;

  sdsus_cmd_side #(.RSP_TMO(RSP_TMO)) u_cmd (
    .clk         (clk),
    .rst         (rst),
    .cmd_issue   (cmd_issue),
    .cmd_suspend (cmd_suspend),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .waiting     (cmd_wait),
    .ack         (susp_ack)
  );

  sdsus_data_side u_dat (
    .clk        (clk),
    .rst        (rst),
    .ack        (susp_ack),
    .cmd_wait   (cmd_wait),
    .cmd_issue  (cmd_issue),
    .xfer_start (xfer_start),
    .xfer_dir   (xfer_dir),
    .xfer_end   (xfer_end),
    .crc_tok    (crc_tok),
    .rd_pkt     (rd_pkt),
    .fifo_empty (fifo_empty),
    .state      (st),
    .pend       (pend),
    .suspended  (suspended)
  );

  assign susp_pend = cmd_wait | pend;
  assign dstate    = st;

  // R11: acknowledge while idle leaves nothing pending
  a_r11_idle_ack: assert property (@(posedge clk) disable iff (rst)
    (susp_ack && st == DS_IDLE && !cmd_issue) |=> !pend);
endmodule

// File: tb/sim_sdsus_ctrl.sv
module sim_sdsus_ctrl;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_issue = 0, cmd_suspend = 0, rsp_valid = 0, rsp_ok = 0;
  logic xfer_start = 0, xfer_dir = 0, xfer_end = 0, crc_tok = 0, rd_pkt = 0;
  logic fifo_empty = 1;
  logic susp_ack, susp_pend, suspended;
  logic [2:0] dstate;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sdsus_ctrl #(.RSP_TMO(TMO)) u0 (
    .clk(clk), .rst(rst), .cmd_issue(cmd_issue), .cmd_suspend(cmd_suspend),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .xfer_start(xfer_start),
    .xfer_dir(xfer_dir), .xfer_end(xfer_end), .crc_tok(crc_tok),
    .rd_pkt(rd_pkt), .fifo_empty(fifo_empty), .susp_ack(susp_ack),
    .susp_pend(susp_pend), .dstate(dstate), .suspended(suspended)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start(logic dir);
    xfer_start = 1; xfer_dir = dir; step(); xfer_start = 0;
  endtask

  task automatic issue(logic s);
    cmd_issue = 1; cmd_suspend = s; step(); cmd_issue = 0; cmd_suspend = 0;
  endtask

  task automatic rsp(logic ok);
    rsp_valid = 1; rsp_ok = ok; step(); rsp_valid = 0; rsp_ok = 0;
  endtask

  task automatic endx();
    xfer_end = 1; step(); xfer_end = 0;
  endtask

  // {dir, expected state}
  localparam logic [3:0] VEC [4] = '{4'b0_001, 4'b1_010, 4'b1_010, 4'b0_001};

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    chk("R1 dstate", dstate, 0);
    chk("R1 ack", susp_ack, 0);
    chk("R1 pend", susp_pend, 0);
    chk("R1 suspended", suspended, 0);

    foreach (VEC[i]) begin
      start(VEC[i][3]);
      chk("R2 start state", dstate, VEC[i][2:0]);
      endx();
      chk("R10 end idle", dstate, 0);
    end

    // write suspend
    start(0);
    issue(1);
    chk("R8 pend after issue", susp_pend, 1);
    rsp(1);
    chk("R3 ack high", susp_ack, 1);
    step();
    chk("R3 ack one cycle", susp_ack, 0);
    chk("R6 still writing", dstate, 1);
    step(); step();
    chk("R6 holds before token", dstate, 1);
    crc_tok = 1; step(); crc_tok = 0;
    chk("R6 idle after token", dstate, 0);
    chk("R6 suspended", suspended, 1);
    chk("R8 pend cleared", susp_pend, 0);
    issue(0);
    chk("R9 suspended cleared", suspended, 0);

    // read suspend
    fifo_empty = 0;
    start(1);
    issue(1);
    rsp(1);
    step();
    step();
    chk("R7 parked", dstate, 3);
    step(); step();
    chk("R7 park holds", dstate, 3);
    rd_pkt = 1; step(); rd_pkt = 0;
    chk("R7 draining", dstate, 4);
    step(); step();
    chk("R7 drain holds", dstate, 4);
    chk("R7 not yet suspended", suspended, 0);
    fifo_empty = 1; step();
    chk("R7 idle after empty", dstate, 0);
    chk("R7 suspended", suspended, 1);
    issue(0);

    // error reply
    start(0);
    issue(1);
    rsp(0);
    chk("R4 no ack on error", susp_ack, 0);
    chk("R4 pend dropped", susp_pend, 0);
    crc_tok = 1; step(); crc_tok = 0;
    chk("R4 write continues", dstate, 1);
    endx();
    chk("R10 idle", dstate, 0);
    chk("R10 not suspended", suspended, 0);

    // timeout
    start(1);
    issue(1);
    repeat (TMO + 2) step();
    chk("R4 pend after timeout", susp_pend, 0);
    rsp(1);
    chk("R4 no ack after timeout", susp_ack, 0);
    step(); step();
    chk("R4 read continues", dstate, 2);
    endx();

    // non-suspend command
    start(0);
    issue(0);
    rsp(1);
    chk("R5 no ack", susp_ack, 0);
    endx();

    // start blocked
    issue(1);
    start(0);
    chk("R8 start blocked", dstate, 0);
    rsp(0);
    start(0);
    chk("R8 start after clear", dstate, 1);
    endx();

    // ack while idle
    issue(1);
    rsp(1);
    chk("R11 ack while idle", susp_ack, 1);
    step();
    chk("R11 nothing pending", susp_pend, 0);
    start(1);
    chk("R11 start ok", dstate, 2);
    endx();

    // end while pending
    start(0);
    issue(1);
    rsp(1);
    step();
    chk("R6 pending latched", susp_pend, 1);
    endx();
    chk("R10 end idle", dstate, 0);
    chk("R10 pend cleared", susp_pend, 0);
    chk("R10 suspended low", suspended, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule